// File: doc/BRIEF.md
# Multi-Block Card Transfer Sequencer

This block steers the data phase of a memory-card host controller. It runs single-block and multi-block transfers in both directions between a host-side FIFO and a card-side data engine. It does not move any data itself. It raises `xfer_en` while the data engine may run, and it drops that signal whenever it must wait.

The sequencer waits in several places:

- After a write command, it waits for the command response and then for software to set the data-enable bit.
- It stops when the FIFO is full on a read or empty on a write.
- Unless auto mode is on, it stops after every block that is not the last one.

Software resumes the sequencer through the data-enable and read-continue bits. Both bits self-clear once they have been taken. A command-off bit cancels the whole sequence so that a stop command can follow. A block counter tracks the blocks that remain. When the last block ends, the sequencer spends one cycle in DONE and then returns to idle.

Top module: `mblk_seq`

## Requirements
- R1: In IDLE, a `xfer_start` pulse with a non-zero `xfer_blocks` loads that count into `blocks_left` and moves to WAIT_RESP. A start with a count of zero, or a start in any other state, is ignored.
- R2: After `resp_rcvd` in WAIT_RESP, a read goes straight to XFER. A write waits in WAIT_EN, with `xfer_en` low, until a data-enable write (control bit 0) is taken.
- R3: In XFER, the sequencer goes to HALT_FIFO when `fifo_empty` is high on a write or `fifo_full` is high on a read. In HALT_FIFO, `halt_code` is 1 and `xfer_en` is 0. A write resumes on a data-enable write. A read resumes on a read-continue write (control bit 1). A `blk_done` in the same cycle wins over the FIFO halt.
- R4: With auto mode off, a `blk_done` that leaves blocks still to move sends the sequencer to HALT_BLOCK, with `halt_code` 2. It goes back to XFER only once both data-enable and read-continue have been written to 1, together or in separate writes.
- R5: With auto mode on (control bit 3, a stored bit), a `blk_done` that is not the last one keeps the sequencer in XFER with no software action.
- R6: Each `blk_done` in XFER decrements `blocks_left`. The done that brings it to zero enters DONE, which shows `seq_done` for one cycle before IDLE.
- R7: Data-enable reads back as 1 from the write that set it until the cycle it is taken, and as 0 after that. Writing 0 to it has no effect.
- R8: A data-enable write is accepted only in WAIT_EN, in HALT_FIFO during a write, and in HALT_BLOCK. At any other time it leaves the readback at 0 and the state unchanged.
- R9: A control write with command-off (bit 2) set, in WAIT_RESP, WAIT_EN, XFER, HALT_FIFO or HALT_BLOCK, enters ABORT on the next cycle and IDLE on the cycle after that. It clears the pending data-enable and read-continue bits and sets `blocks_left` to 0. Abort wins over every other event.
- R10: `ctl_rdata` reads data-enable on bit 0, read-continue on bit 1 and auto mode on bit 3. Bit 2 and bits 7:4 always read 0, whatever was written to them.
- R11: `seq_state` is one-hot with IDLE=bit0, WAIT_RESP=bit1, WAIT_EN=bit2, XFER=bit3, HALT_FIFO=bit4, HALT_BLOCK=bit5, ABORT=bit6 and DONE=bit7. After reset the sequencer is in IDLE, with readback 0 and counter 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data: bit0 data-enable, bit1 read-continue, bit2 command-off, bit3 auto mode |
| ctl_rdata | output | 8 | Control readback |
| xfer_start | input | 1 | Transfer start pulse (taken in IDLE) |
| xfer_is_write | input | 1 | Direction of the started transfer, 1 = write |
| xfer_blocks | input | 8 | Block count for the started transfer |
| resp_rcvd | input | 1 | Command response received strobe |
| fifo_full | input | 1 | Host FIFO full |
| fifo_empty | input | 1 | Host FIFO empty |
| blk_done | input | 1 | Data engine finished one block |
| xfer_en | output | 1 | Data engine may run (state XFER) |
| halt_code | output | 2 | 0 none, 1 FIFO halt, 2 block halt |
| seq_state | output | 8 | One-hot state |
| seq_done | output | 1 | High in DONE |
| blocks_left | output | 8 | Blocks remaining |

## Verification
Every output is decoded from registers. A strobe applied before edge k therefore shows its effect after edge k. The exception is a control write that releases a halt: it sets the pending bit at edge k, and the state moves at edge k+1. So XFER appears two edges after the write, and the readback shows the bit set for exactly one sample. The bench drives inputs at the falling edge and steps its own cycle model once per rising edge. It compares every output at the next falling edge, and adds literal checks of readback and state at the cycles worked out above.

// File: rtl/mblk_pkg.sv
package mblk_pkg;
    localparam int ST_N = 8;

    typedef enum logic [ST_N-1:0] {
        ST_IDLE      = 8'h01,
        ST_WAIT_RESP = 8'h02,
        ST_WAIT_EN   = 8'h04,
        ST_XFER      = 8'h08,
        ST_HALT_FIFO = 8'h10,
        ST_HALT_BLK  = 8'h20,
        ST_ABORT     = 8'h40,
        ST_DONE      = 8'h80
    } seq_state_e;

    localparam int B_DE   = 0;
    localparam int B_CONT = 1;
    localparam int B_OFF  = 2;
    localparam int B_AUTO = 3;
    localparam int N_CTL  = 4;

    localparam logic [1:0] HALT_NONE  = 2'd0;
    localparam logic [1:0] HALT_FIFO  = 2'd1;
    localparam logic [1:0] HALT_BLOCK = 2'd2;
endpackage

// File: rtl/mblk_ctl_regs.sv
module mblk_ctl_regs
    import mblk_pkg::*;
#(
    parameter int CTL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             de_win,
    input  logic             cont_win,
    input  logic             de_take,
    input  logic             cont_take,
    input  logic             flush,
    output logic             de_q,
    output logic             cont_q,
    output logic             auto_q,
    output logic [CTL_W-1:0] ctl_rdata
);
    typedef struct packed {
        logic de;
        logic cont;
        logic auto_m;
    } ctl_t;

    ctl_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (de_take || flush)
            r_d.de = 1'b0;
        else if (ctl_wr && ctl_wdata[B_DE] && de_win)
            r_d.de = 1'b1;
        if (cont_take || flush)
            r_d.cont = 1'b0;
        else if (ctl_wr && ctl_wdata[B_CONT] && cont_win)
            r_d.cont = 1'b1;
        if (ctl_wr)
            r_d.auto_m = ctl_wdata[B_AUTO];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign de_q   = r_q.de;
    assign cont_q = r_q.cont;
    assign auto_q = r_q.auto_m;

    always_comb begin
        ctl_rdata         = '0;
        ctl_rdata[B_DE]   = r_q.de;
        ctl_rdata[B_CONT] = r_q.cont;
        ctl_rdata[B_AUTO] = r_q.auto_m;
    end

    // R8: data-enable outside its windows leaves no trace
    p_de_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_wdata[B_DE] && !de_win && !de_q) |=> !de_q);
    // R7: a taken data-enable clears itself
    p_de_selfclr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        de_take |=> !de_q);
    // R9: abort drops all pending requests
    p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!de_q && !cont_q));
endmodule

// File: rtl/mblk_blk_cnt.sv
module mblk_blk_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt_q,
    output logic             last
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)       cnt_d = '0;
        else if (load) cnt_d = load_val;
        else if (dec)  cnt_d = cnt_q - ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == ONE);

    // R6: never counts below zero
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (cnt_q != '0));
    // R1: start loads the requested count
    p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clr) |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/mblk_fsm.sv
module mblk_fsm
    import mblk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       start_wr,
    input  logic       start_nz,
    input  logic       resp_rcvd,
    input  logic       fifo_full,
    input  logic       fifo_empty,
    input  logic       blk_done,
    input  logic       abort_req,
    input  logic       de_q,
    input  logic       cont_q,
    input  logic       auto_q,
    input  logic       cnt_last,
    output seq_state_e state_q,
    output logic       dir_q,
    output logic       de_win,
    output logic       cont_win,
    output logic       de_take,
    output logic       cont_take,
    output logic       flush,
    output logic       cnt_load,
    output logic       cnt_dec
);
    typedef struct packed {
        seq_state_e st;
        logic       dir;
    } fsm_t;

    fsm_t r_q, r_d;
    logic busy;
    logic abort;

    always_comb begin
        r_d       = r_q;
        de_take   = 1'b0;
        cont_take = 1'b0;
        cnt_load  = 1'b0;
        cnt_dec   = 1'b0;
        busy      = (r_q.st == ST_WAIT_RESP) || (r_q.st == ST_WAIT_EN) ||
                    (r_q.st == ST_XFER) || (r_q.st == ST_HALT_FIFO) ||
                    (r_q.st == ST_HALT_BLK);
        abort     = abort_req && busy;
        de_win    = (r_q.st == ST_WAIT_EN) || (r_q.st == ST_HALT_BLK) ||
                    ((r_q.st == ST_HALT_FIFO) && r_q.dir);
        cont_win  = (r_q.st == ST_HALT_BLK) ||
                    ((r_q.st == ST_HALT_FIFO) && !r_q.dir);
        if (abort) begin
            r_d.st = ST_ABORT;
        end else begin
            unique case (r_q.st)
                ST_IDLE: begin
                    if (start && start_nz) begin
                        r_d.st   = ST_WAIT_RESP;
                        r_d.dir  = start_wr;
                        cnt_load = 1'b1;
                    end
                end
                ST_WAIT_RESP: begin
                    if (resp_rcvd) r_d.st = r_q.dir ? ST_WAIT_EN : ST_XFER;
                end
                ST_WAIT_EN: begin
                    if (de_q) begin
                        r_d.st  = ST_XFER;
                        de_take = 1'b1;
                    end
                end
                ST_XFER: begin
                    if (blk_done) begin
                        cnt_dec = 1'b1;
                        if (cnt_last)    r_d.st = ST_DONE;
                        else if (!auto_q) r_d.st = ST_HALT_BLK;
                    end else if ((r_q.dir && fifo_empty) || (!r_q.dir && fifo_full)) begin
                        r_d.st = ST_HALT_FIFO;
                    end
                end
                ST_HALT_FIFO: begin
                    if (r_q.dir && de_q) begin
                        r_d.st  = ST_XFER;
                        de_take = 1'b1;
                    end else if (!r_q.dir && cont_q) begin
                        r_d.st    = ST_XFER;
                        cont_take = 1'b1;
                    end
                end
                ST_HALT_BLK: begin
                    if (de_q && cont_q) begin
                        r_d.st    = ST_XFER;
                        de_take   = 1'b1;
                        cont_take = 1'b1;
                    end
                end
                ST_ABORT: r_d.st = ST_IDLE;
                ST_DONE:  r_d.st = ST_IDLE;
                default:  r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= ST_IDLE;
            r_q.dir <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_q = r_q.st;
    assign dir_q   = r_q.dir;
    assign flush   = abort;

    // R11: exactly one state bit
    p_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(r_q.st));
    // R9: abort lasts one cycle
    p_abort_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_ABORT) |=> (r_q.st == ST_IDLE));
    // R5: auto mode passes block breaks
    p_auto_no_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_XFER) && blk_done && auto_q && !cnt_last && !abort_req)
        |=> (r_q.st == ST_XFER));
    // R3: write halts on an empty FIFO
    p_fifo_halt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_XFER) && !abort_req && !blk_done && r_q.dir && fifo_empty)
        |=> (r_q.st == ST_HALT_FIFO));
    // R2: no write data before data-enable
    p_write_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_WAIT_EN) && !de_q && !abort_req) |=> (r_q.st == ST_WAIT_EN));
    // R6: completion lasts one cycle
    p_done_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_DONE) |=> (r_q.st == ST_IDLE));
endmodule

// File: rtl/mblk_seq.sv
module mblk_seq
    import mblk_pkg::*;
#(
    parameter int CTL_W = 8,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic [CTL_W-1:0] ctl_rdata,
    input  logic             xfer_start,
    input  logic             xfer_is_write,
    input  logic [CNT_W-1:0] xfer_blocks,
    input  logic             resp_rcvd,
    input  logic             fifo_full,
    input  logic             fifo_empty,
    input  logic             blk_done,
    output logic             xfer_en,
    output logic [1:0]       halt_code,
    output logic [ST_N-1:0]  seq_state,
    output logic             seq_done,
    output logic [CNT_W-1:0] blocks_left
);
    seq_state_e st;
    logic dir, de_win, cont_win, de_take, cont_take, flush;
    logic cnt_load, cnt_dec, cnt_last;
    logic de_q, cont_q, auto_q;

    mblk_ctl_regs #(.CTL_W(CTL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .de_win(de_win), .cont_win(cont_win), .de_take(de_take),
        .cont_take(cont_take), .flush(flush), .de_q(de_q), .cont_q(cont_q),
        .auto_q(auto_q), .ctl_rdata(ctl_rdata)
    );

    mblk_blk_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(xfer_blocks),
        .dec(cnt_dec), .clr(flush), .cnt_q(blocks_left), .last(cnt_last)
    );

    mblk_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start(xfer_start), .start_wr(xfer_is_write),
        .start_nz(|xfer_blocks), .resp_rcvd(resp_rcvd), .fifo_full(fifo_full),
        .fifo_empty(fifo_empty), .blk_done(blk_done),
        .abort_req(ctl_wr && ctl_wdata[B_OFF]), .de_q(de_q), .cont_q(cont_q),
        .auto_q(auto_q), .cnt_last(cnt_last), .state_q(st), .dir_q(dir),
        .de_win(de_win), .cont_win(cont_win), .de_take(de_take),
        .cont_take(cont_take), .flush(flush), .cnt_load(cnt_load), .cnt_dec(cnt_dec)
    );

    assign seq_state = st;
    assign xfer_en   = (st == ST_XFER);
    assign seq_done  = (st == ST_DONE);
    assign halt_code = (st == ST_HALT_FIFO) ? HALT_FIFO :
                       (st == ST_HALT_BLK)  ? HALT_BLOCK : HALT_NONE;

    // R4: a block halt is left only with both resume bits pending
    p_blk_resume_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_HALT_BLK) && !(de_q && cont_q) && !(ctl_wr && ctl_wdata[B_OFF]))
        |=> (st == ST_HALT_BLK));
    // R3: the FIFO halt shows its reason and stops the engine
    p_fifo_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HALT_FIFO) |-> (halt_code == HALT_FIFO && !xfer_en));
    // R10: reserved and command-off bits read zero
    p_rsvd_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rdata[CTL_W-1:N_CTL] == '0) && !ctl_rdata[B_OFF]);
    // Direction only matters while a transfer is in progress
    p_dir_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ((st != ST_IDLE) && (st != ST_ABORT) && (st != ST_DONE)) |=> (dir == $past(dir)) || (st == ST_IDLE));
endmodule

// File: tb/tb_mblk_seq.sv
module tb_mblk_seq;
    localparam int CTL_W = 8;
    localparam int CNT_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_wr = 1'b0;
    logic [CTL_W-1:0] ctl_wdata = '0;
    logic [CTL_W-1:0] ctl_rdata;
    logic xfer_start = 1'b0;
    logic xfer_is_write = 1'b0;
    logic [CNT_W-1:0] xfer_blocks = '0;
    logic resp_rcvd = 1'b0;
    logic fifo_full = 1'b0;
    logic fifo_empty = 1'b0;
    logic blk_done = 1'b0;
    logic xfer_en;
    logic [1:0] halt_code;
    logic [7:0] seq_state;
    logic seq_done;
    logic [CNT_W-1:0] blocks_left;

    int n_vec = 0;
    int n_bad = 0;

    // cycle model state: 0 IDLE 1 WAIT_RESP 2 WAIT_EN 3 XFER 4 HALT_FIFO 5 HALT_BLOCK 6 ABORT 7 DONE
    int m_st = 0;
    logic m_de = 0, m_cont = 0, m_auto = 0, m_dir = 0;
    logic [CNT_W-1:0] m_cnt = '0;

    always #10 clk = ~clk;

    mblk_seq #(.CTL_W(CTL_W), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .xfer_start(xfer_start), .xfer_is_write(xfer_is_write),
        .xfer_blocks(xfer_blocks), .resp_rcvd(resp_rcvd), .fifo_full(fifo_full),
        .fifo_empty(fifo_empty), .blk_done(blk_done), .xfer_en(xfer_en),
        .halt_code(halt_code), .seq_state(seq_state), .seq_done(seq_done),
        .blocks_left(blocks_left)
    );

    function automatic string tag_of(int s);
        case (s)
            0: return "R1";
            1, 2: return "R2";
            4: return "R3";
            5: return "R4";
            6: return "R9";
            default: return "R6";
        endcase
    endfunction

    task automatic model_step();
        int ns = m_st;
        logic busy, abort, dwin, cwin, tde, tco, ld, dc;
        busy = (m_st >= 1) && (m_st <= 5);
        abort = ctl_wr && ctl_wdata[2] && busy;
        dwin = (m_st == 2) || (m_st == 5) || (m_st == 4 && m_dir);
        cwin = (m_st == 5) || (m_st == 4 && !m_dir);
        tde = 0; tco = 0; ld = 0; dc = 0;
        if (abort) ns = 6;
        else case (m_st)
            0: if (xfer_start && xfer_blocks != 0) begin ns = 1; ld = 1; end
            1: if (resp_rcvd) ns = m_dir ? 2 : 3;
            2: if (m_de) begin ns = 3; tde = 1; end
            3: if (blk_done) begin
                   dc = 1;
                   if (m_cnt == 1) ns = 7; else if (!m_auto) ns = 5;
               end else if ((m_dir && fifo_empty) || (!m_dir && fifo_full)) ns = 4;
            4: if (m_dir && m_de) begin ns = 3; tde = 1; end
               else if (!m_dir && m_cont) begin ns = 3; tco = 1; end
            5: if (m_de && m_cont) begin ns = 3; tde = 1; tco = 1; end
            default: ns = 0;
        endcase
        if (tde || abort) m_de = 0; else if (ctl_wr && ctl_wdata[0] && dwin) m_de = 1;
        if (tco || abort) m_cont = 0; else if (ctl_wr && ctl_wdata[1] && cwin) m_cont = 1;
        if (ctl_wr) m_auto = ctl_wdata[3];
        if (abort) m_cnt = '0; else if (ld) m_cnt = xfer_blocks; else if (dc) m_cnt = m_cnt - 1'b1;
        if (ld) m_dir = xfer_is_write;
        m_st = ns;
    endtask

    task automatic compare(string tag);
        logic [7:0] e_st;
        logic [1:0] e_h;
        logic [CTL_W-1:0] e_rd;
        e_st = 8'b1 << m_st;
        e_h = (m_st == 4) ? 2'd1 : (m_st == 5) ? 2'd2 : 2'd0;
        e_rd = {4'b0, m_auto, 1'b0, m_cont, m_de};
        n_vec++;
        if (seq_state !== e_st || halt_code !== e_h || ctl_rdata !== e_rd ||
            xfer_en !== (m_st == 3) || seq_done !== (m_st == 7) || blocks_left !== m_cnt) begin
            n_bad++;
            $display("FAIL %s: state %b/%b halt %0d/%0d rdata %h/%h en %b/%b done %b/%b left %0d/%0d",
                     tag, seq_state, e_st, halt_code, e_h, ctl_rdata, e_rd,
                     xfer_en, (m_st == 3), seq_done, (m_st == 7), blocks_left, m_cnt);
        end
    endtask

    task automatic lit(string tag, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic quiet();
        ctl_wr = 0; ctl_wdata = '0; xfer_start = 0; resp_rcvd = 0; blk_done = 0;
    endtask

    task automatic step(string tag);
        model_step();
        @(negedge clk);
        compare(tag);
        quiet();
    endtask

    task automatic wr(logic [7:0] v);
        ctl_wr = 1; ctl_wdata = v;
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst_n = 1;
        compare("R11 reset");
        lit("R11 reset state", seq_state, 8'h01);

        // R8: data-enable in IDLE ignored
        wr(8'h01); step("R8");
        lit("R8 idle de", ctl_rdata, 0);
        // R1: zero-count start ignored
        xfer_start = 1; xfer_blocks = 0; step("R1");
        lit("R1 zero count", seq_state, 8'h01);
        // R1/R2 write of two blocks
        xfer_start = 1; xfer_is_write = 1; xfer_blocks = 2; step("R1");
        lit("R1 loaded", blocks_left, 2);
        resp_rcvd = 1; step("R2");
        step("R2"); step("R2");
        lit("R2 gated", xfer_en, 0);
        wr(8'h00); step("R7");
        lit("R7 write zero", ctl_rdata, 0);
        wr(8'h01); step("R7");
        lit("R7 pending", ctl_rdata, 1);
        step("R7");
        lit("R7 taken", ctl_rdata, 0);
        lit("R2 running", seq_state, 8'h08);
        // R8: data-enable during XFER ignored
        wr(8'h01); step("R8");
        lit("R8 xfer de", ctl_rdata, 0);
        // R3: FIFO empty on write
        fifo_empty = 1; step("R3");
        lit("R3 halt code", halt_code, 1);
        step("R3");
        fifo_empty = 0; wr(8'h01); step("R3"); step("R3");
        lit("R3 resumed", xfer_en, 1);
        // R4: block break needs both bits
        blk_done = 1; step("R4");
        lit("R4 halt code", halt_code, 2);
        wr(8'h01); step("R4"); step("R4");
        lit("R4 still halted", seq_state, 8'h20);
        wr(8'h02); step("R4"); step("R4");
        lit("R4 resumed", seq_state, 8'h08);
        // R6: last block
        blk_done = 1; step("R6");
        lit("R6 done", seq_done, 1);
        lit("R6 left", blocks_left, 0);
        step("R6");
        // R5: auto read of three blocks
        wr(8'h08); step("R10");
        lit("R10 auto readback", ctl_rdata, 8'h08);
        xfer_start = 1; xfer_is_write = 0; xfer_blocks = 3; step("R1");
        resp_rcvd = 1; step("R2");
        lit("R2 read direct", seq_state, 8'h08);
        fifo_full = 1; step("R3");
        fifo_full = 0; wr(8'h0A); step("R3"); step("R3");
        blk_done = 1; step("R5");
        lit("R5 no halt", seq_state, 8'h08);
        blk_done = 1; step("R5");
        blk_done = 1; fifo_full = 1; step("R6");
        fifo_full = 0;
        lit("R6 auto done", seq_state, 8'h80);
        step("R6");
        // R9: abort from WAIT_EN with a pending data-enable write
        wr(8'h00); step("R9");
        xfer_start = 1; xfer_is_write = 1; xfer_blocks = 4; step("R9");
        resp_rcvd = 1; step("R9");
        wr(8'h05); step("R9");
        lit("R9 abort", seq_state, 8'h40);
        lit("R9 cleared", ctl_rdata, 0);
        lit("R9 counter", blocks_left, 0);
        step("R9");
        lit("R9 idle", seq_state, 8'h01);
        // R10: reserved bits
        wr(8'hF4); step("R10");
        lit("R10 reserved", ctl_rdata, 0);

        // random phase
        for (int i = 0; i < 6000; i++) begin
            logic [7:0] w;
            xfer_start = ($urandom % 8) == 0;
            xfer_is_write = $urandom % 2;
            xfer_blocks = CNT_W'($urandom % 5);
            resp_rcvd = ($urandom % 4) == 0;
            blk_done = ($urandom % 6) == 0;
            if ($urandom % 8 == 0) fifo_full = $urandom % 2;
            if ($urandom % 8 == 0) fifo_empty = $urandom % 2;
            ctl_wr = ($urandom % 5) == 0;
            w = 8'($urandom);
            w[2] = ($urandom % 30) == 0;
            ctl_wdata = w;
            step(tag_of(m_st));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule